// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the entry into an interrupt or software break for a small 8-bit CPU with a 16-bit program counter. At an instruction boundary it checks three sources: a non-maskable request, a maskable request, and a break trigger from the instruction decoder. It picks one of them and then takes over the byte-wide memory port for five cycles. During those cycles it pushes the return address and the status byte onto the stack. It then fetches a two-byte vector and hands back the new program counter, status byte and stack pointer.

The CPU core provides its live PC, status byte and stack pointer. It stalls while `busy_o` is high. It takes `pc_o`, `status_o` and `sp_o` in the cycle when `done_o` pulses. An acknowledge pulse in that same cycle tells the request source which hardware request was serviced, so the source can drop it.

Top module: `irq_entry_seq`

## Requirements
- R1: When entry is accepted, a pending non-maskable request wins over the maskable request and over the break trigger. The maskable request wins over the break trigger.
- R2: While status bit 2 (interrupt disable) is set, the maskable request and the break trigger are ignored: no memory access and no busy. A non-maskable request is still taken.
- R3: The return address pushed for a hardware request is `pc_i` unchanged. For a break it is `pc_i`+1, wrapping at 16 bits.
- R4: The three writes happen in this order. The return high byte goes to 0x0100+sp. The return low byte goes to 0x0100+(sp-1). The status byte goes to 0x0100+(sp-2). Stack offsets wrap within 8 bits. After the sequence, `sp_o` equals sp-3 (mod 256).
- R5: The pushed status byte equals `status_i` with bit 4 (break flag) forced to 1.
- R6: The vector is read low byte then high byte. A non-maskable entry reads 0xFFFA and 0xFFFB. The other two causes read 0xFFFE and 0xFFFF. `pc_o` equals {high, low}.
- R7: After entry, `status_o` equals `status_i` with bits 2 and 4 set.
- R8: Entry starts on the clock edge where `boundary_i` is high. `busy_o` then stays high for exactly five cycles: three write cycles, then two read cycles, with at most one access per cycle. `done_o` pulses for one cycle right after, and `pc_o` is valid in that cycle.
- R9: In the `done_o` cycle, `nmi_ack_o` or `irq_ack_o` pulses for the hardware request that was serviced. A break entry pulses neither.
- R10: Requests are ignored when `boundary_i` is low, and also while a sequence is already running.
- R11: After reset `busy_o`, `done_o`, both acknowledges and both memory strobes are low, and `pc_o`, `status_o`, `sp_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary; entry may start here |
| nmi_req_i | input | 1 | Pending non-maskable request |
| irq_req_i | input | 1 | Pending maskable request |
| brk_i | input | 1 | Break trigger from decoder |
| pc_i | input | 16 | Current program counter |
| status_i | input | 8 | Current status byte |
| sp_i | input | 8 | Current stack pointer |
| mem_rdata_i | input | 8 | Read data, valid in the read cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | New PC loaded (one cycle) |
| pc_o | output | 16 | Vector-loaded program counter |
| status_o | output | 8 | Status after entry |
| sp_o | output | 8 | Stack pointer after pushes |
| nmi_ack_o | output | 1 | Non-maskable request serviced |
| irq_ack_o | output | 1 | Maskable request serviced |

## Verification
A request sampled on clock edge 0 shows up as the high-byte push in the cycle after that edge. The low byte, the status byte, the vector low read and the vector high read follow in the next four cycles. `done_o`, the acknowledge and the new PC, status and stack pointer appear in the sixth cycle. The bench drives inputs and samples outputs on the falling edge, so each check lands in the cycle counted from the accepting edge. A rejected request is confirmed by watching six further cycles with no busy, strobe or done.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 16;
  localparam int unsigned BRK_BIT  = 4;
  localparam int unsigned IDIS_BIT = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_NMI  = 2'd1,
    CAUSE_IRQ  = 2'd2,
    CAUSE_BRK  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PUSH_H = 3'd1,
    ST_PUSH_L = 3'd2,
    ST_PUSH_P = 3'd3,
    ST_VEC_L  = 3'd4,
    ST_VEC_H  = 3'd5
  } state_e;
endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
  import irq_entry_pkg::*;
(
  input  logic   nmi_req_i,
  input  logic   irq_req_i,
  input  logic   brk_i,
  input  logic   idis_i,
  output cause_e cause_o
);
  always_comb begin
    if (nmi_req_i)                cause_o = CAUSE_NMI;
    else if (irq_req_i && !idis_i) cause_o = CAUSE_IRQ;
    else if (brk_i && !idis_i)     cause_o = CAUSE_BRK;
    else                           cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_IDLE:   state_d = start_i ? ST_PUSH_H : ST_IDLE;
      ST_PUSH_H: state_d = ST_PUSH_L;
      ST_PUSH_L: state_d = ST_PUSH_P;
      ST_PUSH_P: state_d = ST_VEC_L;
      ST_VEC_L:  state_d = ST_VEC_H;
      ST_VEC_H:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irq_entry_mux.sv
module irq_entry_mux
  import irq_entry_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
  input  state_e        state_i,
  input  logic [DW-1:0] sp_i,
  input  logic [AW-1:0] ret_i,
  input  logic [DW-1:0] stat_i,
  input  logic [AW-1:0] vec_i,
  output logic          we_o,
  output logic          re_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  always_comb begin
    we_o    = 1'b0;
    re_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_i)
      ST_PUSH_H: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = ret_i[AW-1:DW]; end
      ST_PUSH_L: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = ret_i[DW-1:0]; end
      ST_PUSH_P: begin we_o = 1'b1; addr_o = {STACK_PAGE, sp_i}; wdata_o = stat_i; end
      ST_VEC_L:  begin re_o = 1'b1; addr_o = vec_i; end
      ST_VEC_H:  begin re_o = 1'b1; addr_o = vec_i + AW'(1); end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        boundary_i,
  input  logic        nmi_req_i,
  input  logic        irq_req_i,
  input  logic        brk_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  status_i,
  input  logic [7:0]  sp_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] pc_o,
  output logic [7:0]  status_o,
  output logic [7:0]  sp_o,
  output logic        nmi_ack_o,
  output logic        irq_ack_o
);
  localparam logic [DW-1:0] BRK_MASK  = DW'(1) << BRK_BIT;
  localparam logic [DW-1:0] IDIS_MASK = DW'(1) << IDIS_BIT;

  cause_e        cause, cause_q;
  state_e        state;
  logic          start;
  logic [AW-1:0] ret_q, vec;
  logic [DW-1:0] stat_q, sp_q, vec_lo_q;

  irq_entry_arb u_arb (
    .nmi_req_i (nmi_req_i),
    .irq_req_i (irq_req_i),
    .brk_i     (brk_i),
    .idis_i    (status_i[IDIS_BIT]),
    .cause_o   (cause)
  );

  assign start = (state == ST_IDLE) && boundary_i && (cause != CAUSE_NONE);

  irq_entry_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .state_o (state)
  );

  assign vec = (cause_q == CAUSE_NMI) ? NMI_VEC : IRQ_VEC;

  irq_entry_mux #(.STACK_PAGE(STACK_PAGE)) u_mux (
    .state_i (state),
    .sp_i    (sp_q),
    .ret_i   (ret_q),
    .stat_i  (stat_q),
    .vec_i   (vec),
    .we_o    (mem_we_o),
    .re_o    (mem_re_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q   <= CAUSE_NONE;
      ret_q     <= '0;
      stat_q    <= '0;
      sp_q      <= '0;
      vec_lo_q  <= '0;
      pc_o      <= '0;
      status_o  <= '0;
      done_o    <= 1'b0;
      nmi_ack_o <= 1'b0;
      irq_ack_o <= 1'b0;
    end else begin
      done_o    <= (state == ST_VEC_H);
      nmi_ack_o <= (state == ST_VEC_H) && (cause_q == CAUSE_NMI);
      irq_ack_o <= (state == ST_VEC_H) && (cause_q == CAUSE_IRQ);
      if (start) begin
        cause_q <= cause;
        // break resumes past its own opcode
        ret_q   <= (cause == CAUSE_BRK) ? pc_i + AW'(1) : pc_i;
        stat_q  <= status_i | BRK_MASK;
        sp_q    <= sp_i;
      end
      if (mem_we_o) sp_q <= sp_q - DW'(1);
      if (state == ST_VEC_L) vec_lo_q <= mem_rdata_i;
      if (state == ST_VEC_H) begin
        pc_o     <= {mem_rdata_i, vec_lo_q};
        status_o <= stat_q | IDIS_MASK;
      end
    end
  end

  assign sp_o   = sp_q;
  assign busy_o = (state != ST_IDLE);
endmodule

module irq_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        boundary_i,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [15:0] mem_addr_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        nmi_ack_o,
  input logic        irq_ack_o
);
  p_one_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  p_access_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> busy_o);
  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  p_ack_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_ack_o || irq_ack_o) |-> done_o);
  p_ack_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nmi_ack_o, irq_ack_o}));
  p_push_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[15:8] == 8'h01 && mem_addr_o[7:0] == $past(mem_addr_o[7:0]) - 8'd1));
  p_vec_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + 16'd1));
  p_vec_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (mem_addr_o[15:3] == 13'h1FFF));
  p_start_boundary_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(boundary_i));
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .nmi_ack_o  (nmi_ack_o),
  .irq_ack_o  (irq_ack_o)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        boundary = 0, nmi = 0, irq = 0, brk = 0;
  logic [15:0] pc = 0;
  logic [7:0]  st = 0, sp = 0, rdata;
  logic        we, re, busy, done, nack, iack;
  logic [15:0] addr, pc_o;
  logic [7:0]  wdata, st_o, sp_o;
  int          n_run = 0, n_fail = 0;
  bit          fin = 0;

  always #5 clk = ~clk;
  assign rdata = addr[7:0] ^ 8'h5A;  // bench memory model

  irq_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .nmi_req_i(nmi),
    .irq_req_i(irq), .brk_i(brk), .pc_i(pc), .status_i(st), .sp_i(sp),
    .mem_rdata_i(rdata), .mem_we_o(we), .mem_re_o(re), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .busy_o(busy), .done_o(done), .pc_o(pc_o),
    .status_o(st_o), .sp_o(sp_o), .nmi_ack_o(nack), .irq_ack_o(iack)
  );

  typedef struct packed {
    logic        n, i, b;
    logic [7:0]  s;
    logic [15:0] p;
    logic [7:0]  sp;
    logic [1:0]  k;  // 0 none, 1 nmi, 2 irq, 3 brk
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b1, 8'h00, 16'h1234, 8'hFF, 2'd1},
    '{1'b0, 1'b1, 1'b1, 8'h00, 16'h2000, 8'h80, 2'd2},
    '{1'b0, 1'b0, 1'b1, 8'hC1, 16'h0300, 8'h10, 2'd3},
    '{1'b0, 1'b1, 1'b0, 8'h04, 16'h4000, 8'h40, 2'd0},
    '{1'b1, 1'b0, 1'b0, 8'h04, 16'hABCD, 8'h01, 2'd1},
    '{1'b0, 1'b0, 1'b1, 8'h04, 16'h5555, 8'h33, 2'd0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 16'hFFFF, 8'h02, 2'd3}
  };

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic quiet(input int cyc, input string r);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      chk(!busy && !we && !re && !done, r, {busy, we, re, done}, 0);
    end
  endtask

  task automatic run(input vec_t v);
    logic [15:0] ret, vb, vexp;
    logic [7:0]  ps;
    ret  = (v.k == 2'd3) ? v.p + 16'd1 : v.p;
    vb   = (v.k == 2'd1) ? 16'hFFFA : 16'hFFFE;
    vexp = {(vb[7:0] + 8'd1) ^ 8'h5A, vb[7:0] ^ 8'h5A};
    ps   = v.s | 8'h10;
    nmi = v.n; irq = v.i; brk = v.b; st = v.s; pc = v.p; sp = v.sp; boundary = 1;
    @(negedge clk);
    boundary = 0; nmi = 0; irq = 0; brk = 0;
    if (v.k == 2'd0) begin
      chk(!busy && !we && !re, "R2", {busy, we, re}, 0);
      quiet(5, "R2");
      return;
    end
    chk(busy && we && addr == {8'h01, v.sp} && wdata == ret[15:8], "R1 R3 R4 push hi",
        {addr, wdata}, {8'h01, v.sp, ret[15:8]});
    @(negedge clk);
    chk(we && addr == {8'h01, v.sp - 8'd1} && wdata == ret[7:0], "R3 R4 push lo",
        {addr, wdata}, {8'h01, v.sp - 8'd1, ret[7:0]});
    @(negedge clk);
    chk(we && addr == {8'h01, v.sp - 8'd2} && wdata == ps, "R4 R5 push status",
        {addr, wdata}, {8'h01, v.sp - 8'd2, ps});
    @(negedge clk);
    chk(re && !we && busy && addr == vb, "R6 R8 vec lo", addr, vb);
    @(negedge clk);
    chk(re && busy && addr == vb + 16'd1, "R6 R8 vec hi", addr, vb + 16'd1);
    @(negedge clk);
    chk(done && !busy && pc_o == vexp, "R6 R8 pc load", {done, busy, pc_o}, {2'b10, vexp});
    chk(st_o == (v.s | 8'h14), "R7 status", st_o, v.s | 8'h14);
    chk(sp_o == v.sp - 8'd3, "R4 sp", sp_o, v.sp - 8'd3);
    chk(nack == (v.k == 2'd1) && iack == (v.k == 2'd2), "R9 ack",
        {nack, iack}, {v.k == 2'd1, v.k == 2'd2});
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle", {done, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !done && !we && !re && !nack && !iack, "R11 strobes", {busy, done, we, re}, 0);
    chk(pc_o == 0 && st_o == 0 && sp_o == 0, "R11 regs", {pc_o, st_o, sp_o}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) run(TBL[k]);
    // R10: requests without boundary are ignored
    nmi = 1; irq = 1; brk = 1; st = 0;
    quiet(4, "R10 no boundary");
    nmi = 0; irq = 0; brk = 0;
    // R10: request during a running sequence is ignored
    nmi = 1; pc = 16'h0100; sp = 8'h50; boundary = 1;
    @(negedge clk);
    nmi = 0; irq = 1; boundary = 1;
    for (int c = 0; c < 4; c++) @(negedge clk);
    boundary = 0; irq = 0;
    @(negedge clk);
    chk(done && nack && !iack, "R10 first entry only", {done, nack, iack}, 3'b110);
    @(negedge clk);
    chk(!busy && !we, "R10 no second entry", {busy, we}, 0);
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule